// File: doc/BRIEF.md
# Fast-Page / EDO DRAM Cycle Controller

This block sits between an on-chip bus master and one bank of asynchronous DRAM. It accepts single and burst requests, checks them against a programmable address window, and turns each accepted request into a DRAM cycle. The cycle drives a multiplexed row/column address and the active-low strobes ras_n, cas_n, we_n and oe_n. A one-clock active-low acknowledge, `ta_n`, goes back to the master for each data beat.

Each access has three phases. A row phase asserts RAS with the row address. A column phase follows, holding CAS and the column address for a programmed number of wait cycles, and an acknowledge cycle closes it. Later beats of a burst keep RAS low. Between beats they give CAS one high cycle and move the column up by one word. RAS is released on the falling clock edge inside the final beat's first column cycle. At least one idle clock follows every access. Separate wait counts govern the first beat and the later beats, and the controller raises a programmed zero to one. A configuration flag rejects the widest port-size code when the device is fast-page type.

The master holds `req` and its fields steady until the final acknowledge of the request. It presents each beat's write data before that beat starts.

Top module: `fpd_ctrl`

## Requirements
- R1: A request starts a DRAM cycle only when `((req_addr ^ cfg_base) & cfg_mask) == 0`. Otherwise ras_n, cas_n and ta_n stay high.
- R2: A wait count of 0 (first-beat or burst-beat) behaves exactly like a count of 1. CAS is never low for less than two clocks per beat.
- R3: Timing is counted from the clock edge that accepts a request. The row cycle comes first, then max(first_wait,1) column wait cycles, then one acknowledge cycle with ta_n low. Each later beat takes one CAS-high cycle, max(burst_wait,1) wait cycles and one acknowledge cycle. ta_n is low for exactly one clock per beat.
- R4: cas_n rises on the clock edge that ends the acknowledge cycle. On a read, oe_n is low exactly while cas_n is low, and `rdata` holds the word read during the acknowledge cycle from the next clock on.
- R5: ras_n rises on the falling clock edge inside the first column cycle of the final beat. It stays low through every earlier beat of a burst.
- R6: In a burst, ras_n stays low across beats. cas_n goes high for one clock between beats, and the column address advances by one, wrapping within the column field.
- R7: On a write, we_n is low from the row cycle through the last acknowledge cycle, oe_n stays high, and `dram_wdata` holds the current beat's data.
- R8: `cfg_err` is high when `cfg_port_size` is 2'b11 and `cfg_edo` is 0, and no cycle starts then. With `cfg_edo` = 1, code 2'b11 is accepted.
- R9: After the final acknowledge of a request, ras_n stays high for at least one clock before RAS falls again.
- R10: The word address is `req_addr` shifted right by 2 (port size 2'b00 or 2'b11), 0 (2'b01) or 1 (2'b10). The column is its low COL_W bits and the row the next ROW_W bits.
- R11: While reset is applied and after it is released, ras_n, cas_n, we_n, oe_n and ta_n are high and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | Window base address |
| cfg_mask | input | ADDR_W | Address bits compared against the base (sets window size) |
| cfg_first_wait | input | WAIT_W | Wait cycles for a single access and the first beat of a burst |
| cfg_burst_wait | input | WAIT_W | Wait cycles for each later burst beat |
| cfg_port_size | input | 2 | Port-size code selecting the address shift |
| cfg_edo | input | 1 | 1 = EDO device, 0 = fast-page device |
| req | input | 1 | Request valid, held until the final acknowledge |
| req_addr | input | ADDR_W | Byte address of the first beat |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | BEAT_W | Extra beats after the first (0 = single access) |
| req_wdata | input | DATA_W | Write data for the current beat |
| ta_n | output | 1 | Transfer acknowledge, active low, one clock per beat |
| rdata | output | DATA_W | Read data of the last acknowledged beat |
| cfg_err | output | 1 | Illegal port-size code for the device type |
| dram_addr | output | MA_W | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_wdata | output | DATA_W | Data driven toward the DRAM |
| dram_rdata | input | DATA_W | Data returned by the DRAM |

## Verification
Assertions watch the strobe relations on every clock. The acknowledge is a single-clock pulse and CAS rises right after it. OE is never low without CAS, and WE and OE are never low together. CAS falls only under a held RAS and stays low at least two clocks. RAS is high in the final acknowledge cycle and the clock after it, and no RAS falls for a miss or an illegal port size. The bench scenarios are needed for the exact cycle counts under each pair of wait settings, for the falling-edge timing of RAS, and for the column sequence and wrap within a burst. They also check the address shift per port size and data integrity through a modelled DRAM array.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_TW   = 3'd2,
    S_T2   = 3'd3,
    S_BC   = 3'd4,
    S_PRE  = 3'd5
  } fpd_state_e;

  // A programmed zero wait count is raised to one.
  function automatic int unsigned eff_wait(input int unsigned w);
    return (w == 0) ? 1 : w;
  endfunction

  // Byte-to-word shift selected by the port-size code.
  function automatic int unsigned word_shift(input logic [1:0] ps);
    case (ps)
      2'b01:   return 0;
      2'b10:   return 1;
      default: return 2;
    endcase
  endfunction

  // Widest code is only legal for EDO devices.
  function automatic logic ps_legal(input logic [1:0] ps, input logic edo);
    return !((ps == 2'b11) && !edo);
  endfunction

endpackage

// File: rtl/fpd_decode.sv
module fpd_decode
  import fpd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic [1:0]        ps_i,
  input  logic              edo_i,
  output logic              hit_o,
  output logic              ps_bad_o
);

  assign hit_o    = (((addr_i ^ base_i) & mask_i) == '0);
  assign ps_bad_o = !ps_legal(ps_i, edo_i);

endmodule

// File: rtl/fpd_timer.sv
module fpd_timer
  import fpd_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] load_val_i,
  input  logic              dec_i,
  output logic              done_o
);

  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= WAIT_W'(eff_wait(32'(load_val_i)) - 1);
    end else if (dec_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/fpd_addr.sv
module fpd_addr
  import fpd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROW_W  = 6,
  parameter int COL_W  = 5,
  parameter int BEAT_W = 3,
  parameter int MA_W   = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        ps_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              sel_row_i,
  output logic [MA_W-1:0]   dram_addr_o
);

  logic [ADDR_W-1:0] word;
  logic [COL_W-1:0]  col;
  logic [ROW_W-1:0]  row;

  assign word = addr_i >> word_shift(ps_i);
  assign col  = COL_W'(word) + COL_W'(beat_i);
  assign row  = ROW_W'(word >> COL_W);

  assign dram_addr_o = sel_row_i ? MA_W'(row) : MA_W'(col);

endmodule

// File: rtl/fpd_ctrl.sv
module fpd_ctrl
  import fpd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int ROW_W  = 6,
  parameter int COL_W  = 5,
  parameter int WAIT_W = 4,
  parameter int BEAT_W = 3,
  localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  logic [WAIT_W-1:0] cfg_first_wait,
  input  logic [WAIT_W-1:0] cfg_burst_wait,
  input  logic [1:0]        cfg_port_size,
  input  logic              cfg_edo,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [BEAT_W-1:0] req_len,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ta_n,
  output logic [DATA_W-1:0] rdata,
  output logic              cfg_err,
  output logic [MA_W-1:0]   dram_addr,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [DATA_W-1:0] dram_wdata,
  input  logic [DATA_W-1:0] dram_rdata
);

  fpd_state_e        st, st_nx;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [BEAT_W-1:0] len_q;
  logic [BEAT_W-1:0] beat_q;
  logic [1:0]        ps_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rel_q;

  // Named internal events
  logic hit, ps_bad, tm_done;
  logic ev_idle, ev_start, ev_ack, ev_last_beat, ev_next_beat;
  logic ev_cas_phase, ev_ras_phase;

  fpd_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i   (req_addr),
    .base_i   (cfg_base),
    .mask_i   (cfg_mask),
    .ps_i     (cfg_port_size),
    .edo_i    (cfg_edo),
    .hit_o    (hit),
    .ps_bad_o (ps_bad)
  );

  assign ev_idle      = (st == S_IDLE) || (st == S_PRE);
  assign ev_start     = ev_idle && req && hit && !ps_bad;
  assign ev_ack       = (st == S_T2);
  assign ev_last_beat = (beat_q == len_q);
  assign ev_next_beat = ev_ack && !ev_last_beat;
  assign ev_cas_phase = (st == S_TW) || (st == S_T2);
  assign ev_ras_phase = (st == S_T1) || (st == S_BC) || ev_cas_phase;

  fpd_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ev_start || ev_next_beat),
    .load_val_i (ev_start ? cfg_first_wait : cfg_burst_wait),
    .dec_i      ((st == S_TW) && !tm_done),
    .done_o     (tm_done)
  );

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE, S_PRE: st_nx = ev_start ? S_T1 : S_IDLE;
      S_T1:          st_nx = S_TW;
      S_TW:          st_nx = tm_done ? S_T2 : S_TW;
      S_T2:          st_nx = ev_last_beat ? S_PRE : S_BC;
      S_BC:          st_nx = S_TW;
      default:       st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      len_q   <= '0;
      beat_q  <= '0;
      ps_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st <= st_nx;
      if (ev_start) begin
        addr_q  <= req_addr;
        wr_q    <= req_write;
        len_q   <= req_len;
        beat_q  <= '0;
        ps_q    <= cfg_port_size;
        wdata_q <= req_wdata;
      end
      if (ev_next_beat) begin
        beat_q  <= beat_q + 1'b1;
        wdata_q <= req_wdata;
      end
      if (ev_ack && !wr_q) begin
        rdata_q <= dram_rdata;
      end
    end
  end

  // Early row release: sampled on the falling edge within the final
  // beat's column phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q <= 1'b0;
    end else begin
      rel_q <= ev_cas_phase && ev_last_beat;
    end
  end

  fpd_addr #(
    .ADDR_W (ADDR_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .BEAT_W (BEAT_W),
    .MA_W   (MA_W)
  ) u_addr (
    .addr_i      (addr_q),
    .ps_i        (ps_q),
    .beat_i      (beat_q),
    .sel_row_i   (st == S_T1),
    .dram_addr_o (dram_addr)
  );

  assign ras_n      = !ev_ras_phase || rel_q;
  assign cas_n      = !ev_cas_phase;
  assign oe_n       = !(ev_cas_phase && !wr_q);
  assign we_n       = !(ev_ras_phase && wr_q);
  assign ta_n       = !ev_ack;
  assign rdata      = rdata_q;
  assign dram_wdata = wdata_q;
  assign cfg_err    = ps_bad;

  // ---------------- assertions ----------------
  assert_ta_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ta_n |=> ta_n);

  assert_cas_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ta_n |=> cas_n);

  assert_oe_under_cas_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !cas_n);

  assert_min_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> ta_n);

  assert_cas_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |=> !cas_n);

  assert_cas_under_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(!ras_n));

  assert_ras_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ta_n && ev_last_beat) |-> ras_n);

  assert_we_oe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));

  assert_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && ras_n) |=> ras_n);

  assert_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_idle && !hit) |=> ras_n);

  assert_precharge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ta_n && ras_n) |=> ras_n);

endmodule

// File: tb/tb_fpd_ctrl.sv
module tb_fpd_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int ROW_W  = 6;
  localparam int COL_W  = 5;
  localparam int WAIT_W = 4;
  localparam int BEAT_W = 3;
  localparam int MA_W   = 6;
  localparam int DEPTH  = 1 << (ROW_W + COL_W);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] cfg_base = 16'h4000;
  logic [ADDR_W-1:0] cfg_mask = 16'hC000;
  logic [WAIT_W-1:0] cfg_first_wait = 4'd1;
  logic [WAIT_W-1:0] cfg_burst_wait = 4'd1;
  logic [1:0]        cfg_port_size = 2'b00;
  logic              cfg_edo = 1'b0;
  logic              req = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_write = 1'b0;
  logic [BEAT_W-1:0] req_len = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              ta_n, cfg_err, ras_n, cas_n, we_n, oe_n;
  logic [DATA_W-1:0] rdata, dram_wdata, dram_rdata;
  logic [MA_W-1:0]   dram_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpd_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .WAIT_W(WAIT_W), .BEAT_W(BEAT_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
    .cfg_first_wait(cfg_first_wait), .cfg_burst_wait(cfg_burst_wait),
    .cfg_port_size(cfg_port_size), .cfg_edo(cfg_edo), .req(req),
    .req_addr(req_addr), .req_write(req_write), .req_len(req_len),
    .req_wdata(req_wdata), .ta_n(ta_n), .rdata(rdata), .cfg_err(cfg_err),
    .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
  );

  // ---------------- behavioural DRAM ----------------
  logic [DATA_W-1:0] dmem    [0:DEPTH-1];
  logic [DATA_W-1:0] ref_mem [0:DEPTH-1];
  logic [ROW_W-1:0]  m_row = '0;
  logic [COL_W-1:0]  m_col = '0;

  always @(negedge ras_n) begin
    #1 m_row = dram_addr[ROW_W-1:0];
  end

  always @(negedge cas_n) begin
    #1 m_col = dram_addr[COL_W-1:0];
    if (!we_n) dmem[{m_row, m_col}] = dram_wdata;
  end

  assign dram_rdata = (!cas_n && !oe_n) ? dmem[{m_row, m_col}] : '0;

  // ---------------- bench arithmetic ----------------
  function automatic int ew(input int w);
    return (w < 1) ? 1 : w;
  endfunction

  function automatic int shamt(input logic [1:0] ps);
    if (ps == 2'b01) return 0;
    if (ps == 2'b10) return 1;
    return 2;
  endfunction

  function automatic int col_of(input logic [15:0] a, input logic [1:0] ps, input int b);
    int word;
    word = int'(a) >>> shamt(ps);
    return (word + b) % (1 << COL_W);
  endfunction

  function automatic int row_of(input logic [15:0] a, input logic [1:0] ps);
    int word;
    word = int'(a) >>> shamt(ps);
    return (word >>> COL_W) % (1 << ROW_W);
  endfunction

  function automatic int idx_of(input logic [15:0] a, input logic [1:0] ps, input int b);
    return row_of(a, ps) * (1 << COL_W) + col_of(a, ps, b);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One accepted access, checked cycle by cycle. Called just after a falling edge.
  task automatic run_access(input logic [15:0] a, input bit wr, input int len,
                            input logic [1:0] ps, input int w, input int wb);
    logic [31:0] wd [0:7];
    int b, ph, left, rd_idx, ix;
    bit first_tw, rd_pend, fin, last;
    for (int i = 0; i < 8; i++) wd[i] = $urandom;
    cfg_port_size = ps;
    cfg_first_wait = WAIT_W'(w);
    cfg_burst_wait = WAIT_W'(wb);
    req_addr = a; req_write = wr; req_len = BEAT_W'(len); req_wdata = wd[0]; req = 1'b1;
    b = 0; ph = 1; left = 0; first_tw = 0; rd_pend = 0; rd_idx = 0; fin = 0;
    while (!fin) begin
      @(posedge clk); #1;
      last = (b == len);
      if (rd_pend) begin
        chk(rdata == ref_mem[rd_idx], "R4 read data", rdata, ref_mem[rd_idx]);
        rd_pend = 0;
      end
      case (ph)
        1: begin
          chk(ras_n == 0, "R3 ras low in row cycle", 32'(ras_n), 0);
          chk(cas_n == 1 && ta_n == 1, "R3 cas/ta high in row cycle", {cas_n, ta_n}, 3);
          chk(dram_addr == MA_W'(row_of(a, ps)), "R10 row address", 32'(dram_addr), row_of(a, ps));
          chk(we_n == !wr && oe_n == 1, "R7 we/oe in row cycle", {we_n, oe_n}, {!wr, 1'b1});
        end
        2: begin
          chk(cas_n == 0 && ta_n == 1, "R3 wait cycle cas low ta high", {cas_n, ta_n}, 1);
          chk(ras_n == (last && !first_tw), "R5 ras early in wait", 32'(ras_n), 32'(last && !first_tw));
          chk(dram_addr == MA_W'(col_of(a, ps, b)), "R6 column address", 32'(dram_addr), col_of(a, ps, b));
          chk(oe_n == wr && we_n == !wr, "R4 oe/we in wait", {oe_n, we_n}, {wr, !wr});
          if (wr) chk(dram_wdata == wd[b], "R7 write data held", dram_wdata, wd[b]);
        end
        3: begin
          chk(ta_n == 0 && cas_n == 0, "R3 ack cycle", {ta_n, cas_n}, 0);
          chk(ras_n == last, "R5 ras in ack cycle", 32'(ras_n), 32'(last));
          if (wr) chk(dram_wdata == wd[b], "R7 write data at ack", dram_wdata, wd[b]);
        end
        4: begin
          chk(cas_n == 1 && ta_n == 1 && ras_n == 0, "R6 cas gap keeps ras", {cas_n, ta_n, ras_n}, 6);
          chk(dram_addr == MA_W'(col_of(a, ps, b)), "R6 next column", 32'(dram_addr), col_of(a, ps, b));
        end
        default: begin
          chk(ras_n == 1 && cas_n == 1 && ta_n == 1, "R9 precharge idle", {ras_n, cas_n, ta_n}, 7);
          chk(we_n == 1 && oe_n == 1, "R7 strobes released", {we_n, oe_n}, 3);
        end
      endcase
      @(negedge clk); #1;
      case (ph)
        1: begin
          chk(ras_n == 0, "R5 ras held at row falling edge", 32'(ras_n), 0);
          ph = 2; left = ew(w); first_tw = 1;
        end
        2: begin
          chk(ras_n == last, "R5 ras after falling edge", 32'(ras_n), 32'(last));
          first_tw = 0; left--;
          if (left == 0) ph = 3;
        end
        3: begin
          ix = idx_of(a, ps, b);
          if (wr) begin
            chk(dmem[ix] == wd[b], "R10 write landed at mapped cell", dmem[ix], wd[b]);
            ref_mem[ix] = wd[b];
          end else begin
            rd_pend = 1; rd_idx = ix;
          end
          if (last) begin
            ph = 5; req = 1'b0;
          end else begin
            b++; ph = 4;
            if (wr) req_wdata = wd[b];
          end
        end
        4: begin
          ph = 2; left = ew(wb); first_tw = 1;
        end
        default: fin = 1;
      endcase
    end
  endtask

  // A request that must not start a cycle.
  task automatic run_refused(input logic [15:0] a, input logic [1:0] ps, input bit exp_err, input string tag);
    cfg_port_size = ps;
    req_addr = a; req_write = 1'b1; req_len = '0; req = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      chk(ras_n == 1 && cas_n == 1 && ta_n == 1, tag, {ras_n, cas_n, ta_n}, 7);
    end
    chk(cfg_err == exp_err, "R8 cfg_err level", 32'(cfg_err), 32'(exp_err));
    req = 1'b0;
    @(negedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R3 watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin
      dmem[i] = 32'(i) * 32'h9E37_79B9 + 32'h1234_5678;
      ref_mem[i] = dmem[i];
    end
    #(CLK_PERIOD * 3);
    @(negedge clk); #1;
    // R11 reset state
    chk({ras_n, cas_n, we_n, oe_n, ta_n} == 5'b11111, "R11 strobes high in reset",
        {ras_n, cas_n, we_n, oe_n, ta_n}, 5'b11111);
    chk(rdata == 0, "R11 rdata zero", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk({ras_n, cas_n, we_n, oe_n, ta_n} == 5'b11111, "R11 idle after reset",
        {ras_n, cas_n, we_n, oe_n, ta_n}, 5'b11111);

    // Directed single accesses
    run_access(16'h4124, 1'b1, 0, 2'b00, 2, 1);
    run_access(16'h4124, 1'b0, 0, 2'b00, 2, 1);
    // R2: zero wait counts
    run_access(16'h4124, 1'b0, 0, 2'b00, 0, 0);
    // R6: bursts, write then read, zero burst wait
    run_access(16'h4200, 1'b1, 3, 2'b00, 1, 0);
    run_access(16'h4200, 1'b0, 3, 2'b00, 1, 0);
    // R6: column wrap at the top of a row
    run_access(16'h407C, 1'b1, 2, 2'b00, 1, 2);
    run_access(16'h407C, 1'b0, 2, 2'b00, 3, 1);
    // R1: address outside the window
    run_refused(16'h8124, 2'b00, 1'b0, "R1 miss starts no cycle");
    run_refused(16'h0010, 2'b00, 1'b0, "R1 miss starts no cycle");
    // R8: widest port code on fast-page device
    cfg_edo = 1'b0;
    run_refused(16'h4124, 2'b11, 1'b1, "R8 illegal port size refused");
    // R8: accepted on EDO
    cfg_edo = 1'b1;
    run_access(16'h4300, 1'b1, 0, 2'b11, 1, 1);
    run_access(16'h4300, 1'b0, 1, 2'b11, 1, 1);
    cfg_edo = 1'b0;
    // R10: other port sizes
    run_access(16'h4555, 1'b1, 1, 2'b01, 2, 2);
    run_access(16'h4555, 1'b0, 1, 2'b01, 1, 1);
    run_access(16'h4556, 1'b1, 0, 2'b10, 1, 1);
    run_access(16'h4556, 1'b0, 0, 2'b10, 1, 1);

    // Constrained random mix, back-to-back or with idle gaps
    for (int n = 0; n < 60; n++) begin
      logic [1:0] ps;
      int gap;
      cfg_edo = 1'($urandom % 2);
      ps = 2'($urandom % (cfg_edo ? 4 : 3));
      a = 16'h4000 | 16'($urandom & 32'h3FFF);
      run_access(a, 1'($urandom % 2), int'($urandom % 4), ps,
                 int'($urandom % 4), int'($urandom % 4));
      gap = int'($urandom % 3);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); #1;
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule